// File: doc/BRIEF.md
# Flag-Setting Data-Processing ALU

This block carries out the sixteen data-processing operations of a classic 32-bit RISC integer pipeline. It takes an operation code, a set-flags bit, a first operand, a second operand that an upstream shifter has already shifted or rotated, the shifter's carry-out, the current condition flags and a marker saying that the destination register is the program counter. From these it produces the result, a write enable for the register file, the next condition flags with their update enable, and a request to restore the saved status word.

Operations arrive on a valid/ready stream. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its outputs are held in one register stage and shown on the output stream the next cycle. The stage accepts a new operation while it is empty or while its current output is being taken. Back-pressure on `out_ready` therefore stops the input at once. The output values stay frozen for as long as `out_valid` is high and `out_ready` is low.

Top module: `dp_flag_alu`

## Requirements
- R1: `in_ready` is low whenever `out_valid` is high and `out_ready` is low. An operation accepted on one edge is shown with `out_valid` high after that edge. While the output is stalled, every output value stays unchanged.
- R2: The arithmetic codes compute these results modulo 2^32. SUB=2 gives op1-op2. RSB=3 gives op2-op1. ADD=4 gives op1+op2. ADC=5 gives op1+op2+C. SBC=6 gives op1-op2-(1-C). RSC=7 gives op2-op1-(1-C). C is the incoming carry flag.
- R3: The logical codes compute these results. AND=0 gives op1&op2. EOR=1 gives op1^op2. ORR=12 gives op1|op2. MOV=13 gives op2, whatever op1 is. BIC=14 gives op1&~op2. MVN=15 gives ~op2.
- R4: The compare codes are TST=8 (AND), TEQ=9 (XOR), CMP=10 (subtract) and CMN=11 (add). For these codes `out_wr_en` is 0, while `out_result` still carries the computed value. Every other code gives `out_wr_en` = 1.
- R5: For ADD, ADC and CMN, C is the unsigned carry out of bit 31 and V is the two's-complement overflow.
- R6: For SUB, RSB, SBC, RSC and CMP, C is 1 exactly when no borrow occurs, that is when the minuend is unsigned greater than or equal to the subtrahend plus the borrow. V is the two's-complement overflow.
- R7: The flag vectors are packed as {N,Z,C,V}, with N in bit 3 and V in bit 0. When flags are updated, N is bit 31 of the result and Z is 1 exactly when the result is zero.
- R8: For the logical and test codes (0, 1, 8, 9, 12, 13, 14, 15), an updated C equals `in_shift_c` and an updated V equals the incoming V.
- R9: Flags are updated when the set-flags bit is 1 or the code is a compare. When neither holds, `out_flags_we` is 0 and `out_flags` equals `in_flags`.
- R10: Take an operation that would update flags. If its destination is the program counter, `out_flags_we` is 0, `out_flags` equals `in_flags` and `out_restore_req` is 1. In every other case `out_restore_req` is 0.
- R11: While `rst_n` is low, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The stage can take the offered operation |
| in_opcode | input | 4 | Operation code, 0 to 15 |
| in_setf | input | 1 | Set-flags request |
| in_dst_pc | input | 1 | Destination register is the program counter |
| in_op1 | input | WIDTH | First operand |
| in_op2 | input | WIDTH | Second operand, already shifted |
| in_shift_c | input | 1 | Carry-out from the shifter |
| in_flags | input | 4 | Current flags {N,Z,C,V} |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | WIDTH | Computed value |
| out_wr_en | output | 1 | Write the result to the destination |
| out_flags | output | 4 | Next flags {N,Z,C,V} |
| out_flags_we | output | 1 | Commit `out_flags` |
| out_restore_req | output | 1 | Request restore of the saved status word |

## Verification
The bench builds the block with WIDTH at its default of 32, which is the width the flag definitions refer to. At this width the operand corners 0, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF reach both edges of signed overflow and the wrap of unsigned carry and borrow. Every code is run over every pair of these corners with the carry in at 0 and at 1. Random operands, random set-flags values and occasional program-counter destinations follow, so that suppression and restore requests are exercised. A randomly toggled `out_ready` exercises stalls and back-to-back transfers.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  localparam int FLG_N = 3;
  localparam int FLG_Z = 2;
  localparam int FLG_C = 1;
  localparam int FLG_V = 0;

  typedef enum logic [3:0] {
    OPC_AND = 4'd0,  OPC_EOR = 4'd1,  OPC_SUB = 4'd2,  OPC_RSB = 4'd3,
    OPC_ADD = 4'd4,  OPC_ADC = 4'd5,  OPC_SBC = 4'd6,  OPC_RSC = 4'd7,
    OPC_TST = 4'd8,  OPC_TEQ = 4'd9,  OPC_CMP = 4'd10, OPC_CMN = 4'd11,
    OPC_ORR = 4'd12, OPC_MOV = 4'd13, OPC_BIC = 4'd14, OPC_MVN = 4'd15
  } opcode_e;

  typedef enum logic [1:0] {
    KIND_LOGIC = 2'd0,
    KIND_ADD   = 2'd1,
    KIND_SUB   = 2'd2
  } kind_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_FLAG = 2'd2
  } cin_sel_e;

  typedef enum logic [2:0] {
    LG_AND  = 3'd0,
    LG_XOR  = 3'd1,
    LG_OR   = 3'd2,
    LG_PASS = 3'd3,
    LG_ANDN = 3'd4,
    LG_NOT  = 3'd5
  } logic_sel_e;

  typedef struct packed {
    kind_e      kind;
    logic       swap;     // operand2 becomes the left operand
    logic       inv_y;    // right operand inverted (subtract)
    cin_sel_e   cin_sel;
    logic       is_cmp;   // flags only, no write-back
    logic_sel_e lsel;
  } dec_t;

endpackage

// File: rtl/dp_op_decode.sv
module dp_op_decode
  import dp_alu_pkg::*;
(
  input  logic [3:0] opcode,
  output dec_t       dec
);

  always_comb begin
    dec = '{kind: KIND_LOGIC, swap: 1'b0, inv_y: 1'b0, cin_sel: CIN_ZERO,
            is_cmp: 1'b0, lsel: LG_AND};
    unique case (opcode_e'(opcode))
      OPC_AND: dec.lsel = LG_AND;
      OPC_EOR: dec.lsel = LG_XOR;
      OPC_SUB: begin dec.kind = KIND_SUB; dec.inv_y = 1'b1; dec.cin_sel = CIN_ONE; end
      OPC_RSB: begin dec.kind = KIND_SUB; dec.inv_y = 1'b1; dec.cin_sel = CIN_ONE; dec.swap = 1'b1; end
      OPC_ADD: dec.kind = KIND_ADD;
      OPC_ADC: begin dec.kind = KIND_ADD; dec.cin_sel = CIN_FLAG; end
      OPC_SBC: begin dec.kind = KIND_SUB; dec.inv_y = 1'b1; dec.cin_sel = CIN_FLAG; end
      OPC_RSC: begin dec.kind = KIND_SUB; dec.inv_y = 1'b1; dec.cin_sel = CIN_FLAG; dec.swap = 1'b1; end
      OPC_TST: begin dec.lsel = LG_AND; dec.is_cmp = 1'b1; end
      OPC_TEQ: begin dec.lsel = LG_XOR; dec.is_cmp = 1'b1; end
      OPC_CMP: begin dec.kind = KIND_SUB; dec.inv_y = 1'b1; dec.cin_sel = CIN_ONE; dec.is_cmp = 1'b1; end
      OPC_CMN: begin dec.kind = KIND_ADD; dec.is_cmp = 1'b1; end
      OPC_ORR: dec.lsel = LG_OR;
      OPC_MOV: dec.lsel = LG_PASS;
      OPC_BIC: dec.lsel = LG_ANDN;
      OPC_MVN: dec.lsel = LG_NOT;
      default: dec.lsel = LG_AND;
    endcase
  end

endmodule

// File: rtl/dp_add_unit.sv
module dp_add_unit #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] wide;

  always_comb begin
    wide = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
    sum  = wide[MSB:0];
    cout = wide[WIDTH];
    // Overflow: like-signed inputs giving a result of the other sign.
    ovf  = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
  end

endmodule

// File: rtl/dp_logic_unit.sv
module dp_logic_unit
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic_sel_e       sel,
  output logic [WIDTH-1:0] y
);

  always_comb begin
    unique case (sel)
      LG_AND:  y = a & b;
      LG_XOR:  y = a ^ b;
      LG_OR:   y = a | b;
      LG_PASS: y = b;
      LG_ANDN: y = a & ~b;
      LG_NOT:  y = ~b;
      default: y = a & b;
    endcase
  end

endmodule

// File: rtl/dp_flag_alu.sv
module dp_flag_alu
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [3:0]       in_opcode,
  input  logic             in_setf,
  input  logic             in_dst_pc,
  input  logic [WIDTH-1:0] in_op1,
  input  logic [WIDTH-1:0] in_op2,
  input  logic             in_shift_c,
  input  logic [3:0]       in_flags,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_result,
  output logic             out_wr_en,
  output logic [3:0]       out_flags,
  output logic             out_flags_we,
  output logic             out_restore_req
);

  localparam int MSB = WIDTH - 1;

  dec_t             dec;
  logic [WIDTH-1:0] x_opd, y_raw, y_opd;
  logic             cin;
  logic [WIDTH-1:0] add_sum, lg_val, res;
  logic             add_c, add_v;
  logic             upd, nxt_we, nxt_rr;
  logic [3:0]       calc_flags, nxt_flags;
  logic             accept;

  dp_op_decode u_dec (
    .opcode (in_opcode),
    .dec    (dec)
  );

  // Operand steering: one adder serves add, subtract and reverse forms.
  always_comb begin
    x_opd = dec.swap ? in_op2 : in_op1;
    y_raw = dec.swap ? in_op1 : in_op2;
    y_opd = dec.inv_y ? ~y_raw : y_raw;
    unique case (dec.cin_sel)
      CIN_ONE:  cin = 1'b1;
      CIN_FLAG: cin = in_flags[FLG_C];
      default:  cin = 1'b0;
    endcase
  end

  dp_add_unit #(.WIDTH(WIDTH)) u_add (
    .x    (x_opd),
    .y    (y_opd),
    .cin  (cin),
    .sum  (add_sum),
    .cout (add_c),
    .ovf  (add_v)
  );

  dp_logic_unit #(.WIDTH(WIDTH)) u_lgc (
    .a   (in_op1),
    .b   (in_op2),
    .sel (dec.lsel),
    .y   (lg_val)
  );

  always_comb begin
    res = (dec.kind == KIND_LOGIC) ? lg_val : add_sum;
    calc_flags[FLG_N] = res[MSB];
    calc_flags[FLG_Z] = (res == '0);
    calc_flags[FLG_C] = (dec.kind == KIND_LOGIC) ? in_shift_c : add_c;
    calc_flags[FLG_V] = (dec.kind == KIND_LOGIC) ? in_flags[FLG_V] : add_v;
    upd       = in_setf | dec.is_cmp;
    nxt_we    = upd & ~in_dst_pc;
    nxt_rr    = upd & in_dst_pc;
    nxt_flags = nxt_we ? calc_flags : in_flags;
  end

  // Single output stage: accept when empty or being drained.
  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid       <= 1'b0;
      out_result      <= '0;
      out_wr_en       <= 1'b0;
      out_flags       <= '0;
      out_flags_we    <= 1'b0;
      out_restore_req <= 1'b0;
    end else begin
      if (accept) begin
        out_valid       <= 1'b1;
        out_result      <= res;
        out_wr_en       <= ~dec.is_cmp;
        out_flags       <= nxt_flags;
        out_flags_we    <= nxt_we;
        out_restore_req <= nxt_rr;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dp_flag_alu_chk.sv
module dp_flag_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [3:0]       in_opcode,
  input logic             in_shift_c,
  input logic [3:0]       in_flags,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_result,
  input logic             out_wr_en,
  input logic [3:0]       out_flags,
  input logic             out_flags_we,
  input logic             out_restore_req
);

  localparam int MSB = WIDTH - 1;

  logic       acc_q;
  logic [3:0] op_q;
  logic [3:0] flg_q;
  logic       shc_q;
  logic       op_is_cmp, op_is_logic;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
      op_q  <= '0;
      flg_q <= '0;
      shc_q <= 1'b0;
    end else begin
      acc_q <= in_valid && in_ready;
      if (in_valid && in_ready) begin
        op_q  <= in_opcode;
        flg_q <= in_flags;
        shc_q <= in_shift_c;
      end
    end
  end

  assign op_is_cmp   = (op_q >= 4'd8) && (op_q <= 4'd11);
  assign op_is_logic = (op_q <= 4'd1) || (op_q == 4'd8) || (op_q == 4'd9) || (op_q >= 4'd12);

  AST_ACCEPT_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q |-> out_valid); // R1
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R1
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_flags)
      && $stable(out_wr_en) && $stable(out_flags_we) && $stable(out_restore_req)); // R1
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q |-> (out_wr_en == !op_is_cmp)); // R4
  AST_NZ_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flags_we |-> (out_flags[3] == out_result[MSB])
      && (out_flags[2] == (out_result == '0))); // R7
  AST_LOGIC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q && out_flags_we && op_is_logic |-> (out_flags[1] == shc_q)
      && (out_flags[0] == flg_q[0])); // R8
  AST_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q && !out_flags_we |-> out_flags == flg_q); // R9
  AST_RESTORE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_restore_req |-> !out_flags_we); // R10
  AST_RESET_EMPTY: assert property (@(posedge clk)
    !rst_n |-> !out_valid); // R11

endmodule

bind dp_flag_alu dp_flag_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .in_valid        (in_valid),
  .in_ready        (in_ready),
  .in_opcode       (in_opcode),
  .in_shift_c      (in_shift_c),
  .in_flags        (in_flags),
  .out_valid       (out_valid),
  .out_ready       (out_ready),
  .out_result      (out_result),
  .out_wr_en       (out_wr_en),
  .out_flags       (out_flags),
  .out_flags_we    (out_flags_we),
  .out_restore_req (out_restore_req)
);

// File: tb/dp_flag_alu_bench.sv
module dp_flag_alu_bench;

  localparam int W     = 32;
  localparam int NDIR  = 512;
  localparam int NTOT  = 3000;

  typedef struct {
    logic [3:0]   op;
    logic [W-1:0] res;
    logic         we;
    logic [3:0]   fl;
    logic         fwe;
    logic         rr;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [3:0]   in_opcode = '0;
  logic         in_setf = 1'b0;
  logic         in_dst_pc = 1'b0;
  logic [W-1:0] in_op1 = '0;
  logic [W-1:0] in_op2 = '0;
  logic         in_shift_c = 1'b0;
  logic [3:0]   in_flags = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [W-1:0] out_result;
  logic         out_wr_en;
  logic [3:0]   out_flags;
  logic         out_flags_we;
  logic         out_restore_req;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dp_flag_alu #(.WIDTH(W)) u_dp_flag_alu (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_ready (in_ready),
    .in_opcode (in_opcode), .in_setf (in_setf), .in_dst_pc (in_dst_pc),
    .in_op1 (in_op1), .in_op2 (in_op2), .in_shift_c (in_shift_c), .in_flags (in_flags),
    .out_valid (out_valid), .out_ready (out_ready),
    .out_result (out_result), .out_wr_en (out_wr_en),
    .out_flags (out_flags), .out_flags_we (out_flags_we),
    .out_restore_req (out_restore_req)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=0x%08h exp=0x%08h", tag, what, act, exp);
    end
  endtask

  // Behavioural model: wide integer arithmetic, flags from value ranges.
  function automatic exp_t model(input logic [3:0] op, input logic setf, input logic pc,
                                 input logic [W-1:0] a, input logic [W-1:0] b,
                                 input logic shc, input logic [3:0] fi);
    exp_t e;
    longint unsigned ua = a, ub = b;
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint unsigned cy = fi[1];
    longint unsigned u;
    longint s;
    logic c, v, arith, upd;
    c = shc; v = fi[0]; arith = 1'b1; u = 0; s = 0;
    case (op)
      4'd2, 4'd10: begin u = ua - ub; s = sa - sb; c = (ua >= ub); end
      4'd3:        begin u = ub - ua; s = sb - sa; c = (ub >= ua); end
      4'd4, 4'd11: begin u = ua + ub; s = sa + sb; c = (u >= 64'h1_0000_0000); end
      4'd5:        begin u = ua + ub + cy; s = sa + sb + longint'(cy); c = (u >= 64'h1_0000_0000); end
      4'd6:        begin u = ua - ub - (1 - cy); s = sa - sb - longint'(1 - cy); c = (ua >= ub + (1 - cy)); end
      4'd7:        begin u = ub - ua - (1 - cy); s = sb - sa - longint'(1 - cy); c = (ub >= ua + (1 - cy)); end
      default:     arith = 1'b0;
    endcase
    if (arith) begin
      e.res = u[W-1:0];
      v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    end else begin
      case (op)
        4'd0, 4'd8: e.res = a & b;
        4'd1, 4'd9: e.res = a ^ b;
        4'd12:      e.res = a | b;
        4'd13:      e.res = b;
        4'd14:      e.res = a & ~b;
        default:    e.res = ~b;
      endcase
    end
    e.op  = op;
    e.we  = !(op >= 4'd8 && op <= 4'd11);
    upd   = setf || !e.we;
    e.fwe = upd && !pc;
    e.rr  = upd && pc;
    e.fl  = e.fwe ? {e.res[W-1], e.res == '0, c, v} : fi;
    return e;
  endfunction

  function automatic logic [W-1:0] corner(input int k);
    case (k)
      0: return 32'h0000_0000;
      1: return 32'h7FFF_FFFF;
      2: return 32'h8000_0000;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  task automatic make_stim(input int idx);
    if (idx < NDIR) begin
      in_opcode  = idx[3:0];
      in_op1     = corner(idx[5:4]);
      in_op2     = corner(idx[7:6]);
      in_setf    = 1'b1;
      in_dst_pc  = 1'b0;
      in_shift_c = idx[0] ^ idx[4];
      in_flags   = {idx[2], idx[5], idx[8], idx[7]};
    end else begin
      in_opcode  = 4'($urandom);
      in_op1     = ($urandom % 5 == 0) ? corner(int'($urandom % 4)) : $urandom;
      in_op2     = ($urandom % 5 == 0) ? W'($urandom % 4) : $urandom;
      in_setf    = 1'($urandom);
      in_dst_pc  = ($urandom % 8) == 0;
      in_shift_c = 1'($urandom);
      in_flags   = 4'($urandom);
    end
  endtask

  task automatic compare(input exp_t e);
    bit arith = (e.op >= 4'd2 && e.op <= 4'd7) || e.op == 4'd10 || e.op == 4'd11;
    bit addk  = (e.op == 4'd4 || e.op == 4'd5 || e.op == 4'd11);
    string ctag;
    chk(out_result == e.res, arith ? "R2" : "R3", "result", out_result, e.res);
    chk(out_wr_en == e.we, "R4", "wr_en", W'(out_wr_en), W'(e.we));
    chk(out_flags_we == e.fwe, "R9", "flags_we", W'(out_flags_we), W'(e.fwe));
    chk(out_restore_req == e.rr, "R10", "restore", W'(out_restore_req), W'(e.rr));
    if (e.fwe) begin
      chk(out_flags[3:2] == e.fl[3:2], "R7", "NZ", W'(out_flags), W'(e.fl));
      ctag = !arith ? "R8" : (addk ? "R5" : "R6");
      chk(out_flags[1:0] == e.fl[1:0], ctag, "CV", W'(out_flags), W'(e.fl));
    end else begin
      chk(out_flags == e.fl, e.rr ? "R10" : "R9", "kept flags", W'(out_flags), W'(e.fl));
    end
  endtask

  initial begin
    exp_t q[$];
    int sent = 0;
    int recv = 0;
    bit need_new = 1;
    bit hold_armed = 0;
    logic [W-1:0] hold_res = '0;
    logic [3:0] hold_flg = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R11", "valid in reset", W'(out_valid), 0);
    rst_n = 1'b1;
    while (recv < NTOT) begin
      @(negedge clk);
      if (need_new) begin
        if (sent < NTOT) begin
          make_stim(sent);
          in_valid = 1'b1;
        end else begin
          in_valid = 1'b0;
        end
      end
      out_ready = ($urandom % 4) != 0;
      #1;
      if (hold_armed) begin
        chk(out_valid && out_result == hold_res && out_flags == hold_flg,
            "R1", "stall hold", out_result, hold_res);
      end
      hold_armed = out_valid && !out_ready;
      hold_res = out_result;
      hold_flg = out_flags;
      if (hold_armed) chk(!in_ready, "R1", "ready while stalled", W'(in_ready), 0);
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          chk(1'b0, "R1", "unexpected output", W'(out_valid), 0);
        end else begin
          compare(q.pop_front());
        end
        recv++;
      end
      need_new = 0;
      if (in_valid && in_ready) begin
        q.push_back(model(in_opcode, in_setf, in_dst_pc, in_op1, in_op2, in_shift_c, in_flags));
        sent++;
        need_new = 1;
      end
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule